// File: doc/BRIEF.md
# Dual Game Controller Serial Poller

This block scans two serial game controllers of the parallel-load shift-register kind on its own schedule, with no involvement from the host. One latch output and one clock output go to both controllers, and each controller returns its buttons on its own serial data input. A scan begins every `PERIOD_CYC` system clock cycles. It raises the latch to load the controllers' buttons, then sends a train of clock pulses and samples both data lines just before each rising clock edge.

The controllers drive their data active-low, so each sampled bit is inverted and a stored 1 means "pressed". A 16-bit word is built for each controller. At the end of the scan, the low and high bytes of both controllers are copied into holding registers in a single cycle. The host can read these registers at any time and never sees a half-finished scan.

A mode input chooses between an 8-pulse scan for basic controllers and a 16-pulse scan for extended ones. Its value is taken when a scan starts. In basic mode the high bytes are written as zero. Timing is given in system clock cycles through parameters: the defaults give a 12 us latch, 6 us clock phases and a scan rate of 1 kHz at 50 MHz.

Top module: `dual_pad_scanner`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `pad_latch` and `pad_clk` are 0 and all four snapshot bytes are 0 after that edge. The first scan starts at the `PERIOD_CYC`-th rising edge after reset is released.
- R2: A scan starts every `PERIOD_CYC` clock edges. `pad_latch` is then high for exactly `LATCH_CYC` cycles, and `pad_clk` stays low during that time.
- R3: After the latch falls, each clock pulse is `HALF_CYC` cycles low followed by `HALF_CYC` cycles high. `pad_clk` and `pad_latch` are never high together, and both are low between scans.
- R4: A scan issues 16 clock pulses if `wide_mode` was 1 at the edge that started it, and 8 pulses if it was 0. Changing `wide_mode` during a scan does not affect that scan.
- R5: Each data input is sampled at the last edge of every low phase. The k-th sample (k counted from 0) is inverted and stored at bit k of that controller's 16-bit word. The low byte holds bits 7..0 and the high byte holds bits 15..8.
- R6: The snapshot bytes change only at the edge that ends the last high phase of a scan. All four bytes are updated at that edge, and they stay constant at every other time.
- R7: A scan in basic mode (8 pulses) writes 0 to both high bytes.
- R8: Both controllers are sampled at the same edges, and each controller's word depends only on its own data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wide_mode | input | 1 | 1 selects 16-bit scans, 0 selects 8-bit scans; taken at scan start |
| pad0_sd | input | 1 | Serial data from controller 0, active low |
| pad1_sd | input | 1 | Serial data from controller 1, active low |
| pad_latch | output | 1 | Shared latch pulse to both controllers |
| pad_clk | output | 1 | Shared shift clock to both controllers |
| pad0_lo | output | 8 | Controller 0 buttons, bits 7..0, 1 = pressed |
| pad0_hi | output | 8 | Controller 0 buttons, bits 15..8 (zero in basic mode) |
| pad1_lo | output | 8 | Controller 1 buttons, bits 7..0, 1 = pressed |
| pad1_hi | output | 8 | Controller 1 buttons, bits 15..8 (zero in basic mode) |

## Verification
The assertions assume that `PERIOD_CYC` is longer than a 16-pulse scan, so a new period never arrives while a scan is still running. They place no restriction on `wide_mode`, which can change at any time. The bench uses a short period that still leaves idle time after the longest scan. It models each controller as a shift register that loads on the latch and advances on each rising `pad_clk`. Button patterns are changed only between scans, as a real controller holds its loaded state, while `wide_mode` is also toggled in the middle of some scans.

// File: rtl/dual_pad_scanner.sv
module dual_pad_scanner #(
  parameter int LATCH_CYC  = 600,
  parameter int HALF_CYC   = 300,
  parameter int PERIOD_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wide_mode,
  input  logic       pad0_sd,
  input  logic       pad1_sd,
  output logic       pad_latch,
  output logic       pad_clk,
  output logic [7:0] pad0_lo,
  output logic [7:0] pad0_hi,
  output logic [7:0] pad1_lo,
  output logic [7:0] pad1_hi
);
  localparam int MAXD = (LATCH_CYC > HALF_CYC) ? LATCH_CYC : HALF_CYC;
  localparam int CW   = $clog2(MAXD) + 1;
  localparam int PW   = $clog2(PERIOD_CYC) + 1;

  typedef enum logic [1:0] {S_IDLE, S_LATCH, S_LOW, S_HIGH} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic [3:0]    bitn;
  logic          wide_q;
  logic [15:0]   sh0, sh1;

  wire tick     = (pcnt == PW'(PERIOD_CYC - 1));
  wire cnt_done = (cnt == '0);
  wire last_bit = (bitn == (wide_q ? 4'd15 : 4'd7));
  wire commit   = (st == S_HIGH) && cnt_done && last_bit;

  assign pad_latch = (st == S_LATCH);
  assign pad_clk   = (st == S_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      wide_q  <= 1'b0;
      sh0     <= '0;
      sh1     <= '0;
      pad0_lo <= '0;
      pad0_hi <= '0;
      pad1_lo <= '0;
      pad1_hi <= '0;
    end else begin
      case (st)
        S_IDLE: if (tick) begin
          st     <= S_LATCH;
          cnt    <= CW'(LATCH_CYC - 1);
          wide_q <= wide_mode;
          bitn   <= '0;
        end
        S_LATCH: if (cnt_done) begin
          st  <= S_LOW;
          cnt <= CW'(HALF_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_LOW: if (cnt_done) begin
          sh0[bitn] <= ~pad0_sd;
          sh1[bitn] <= ~pad1_sd;
          st        <= S_HIGH;
          cnt       <= CW'(HALF_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_HIGH: if (cnt_done) begin
          if (last_bit) begin
            st      <= S_IDLE;
            pad0_lo <= sh0[7:0];
            pad1_lo <= sh1[7:0];
            pad0_hi <= wide_q ? sh0[15:8] : 8'h00;
            pad1_hi <= wide_q ? sh1[15:8] : 8'h00;
          end else begin
            bitn <= bitn + 1'b1;
            st   <= S_LOW;
            cnt  <= CW'(HALF_CYC - 1);
          end
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  latch_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_latch && pad_clk));

  // R2
  latch_on_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pad_latch && !pad_clk && st == S_IDLE && tick) |=> pad_latch);

  // R2
  latch_only_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !tick) |=> !pad_latch);

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> (st == S_IDLE || $stable(wide_q)));

  // R5
  bitn_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitn <= (wide_q ? 4'd15 : 4'd7));

  // R6
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({pad0_lo, pad0_hi, pad1_lo, pad1_hi}));

  // R7
  basic_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wide_q) |=> (pad0_hi == 8'h00 && pad1_hi == 8'h00));
endmodule

// File: tb/dual_pad_scanner_tb.sv
module dual_pad_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT  = 4;
  localparam int HALF = 3;
  localparam int PER  = 150;
  localparam int NSCAN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0;
  logic pad0_sd = 1'b1;
  logic pad1_sd = 1'b1;
  logic pad_latch, pad_clk;
  logic [7:0] pad0_lo, pad0_hi, pad1_lo, pad1_hi;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dual_pad_scanner #(.LATCH_CYC(LAT), .HALF_CYC(HALF), .PERIOD_CYC(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .pad0_sd(pad0_sd), .pad1_sd(pad1_sd),
    .pad_latch(pad_latch), .pad_clk(pad_clk),
    .pad0_lo(pad0_lo), .pad0_hi(pad0_hi), .pad1_lo(pad1_lo), .pad1_hi(pad1_hi));

  int checks = 0, fails = 0, edges = 0, cyc = 0, off = -1;
  bit started = 0, mwide = 0;
  logic [15:0] pat0 = '0, pat1 = '0, mp0, mp1;
  logic [7:0] e0lo = 0, e0hi = 0, e1lo = 0, e1hi = 0;
  int rises0 = 0;
  logic prev_clk = 0;

  function automatic logic [15:0] mkpat(input int i, input int c);
    case (i % 6)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return c ? 16'h5AA5 : 16'hA55A;
      3: return 16'h0001 << ((i + 5 * c) % 16);
      4: return c ? 16'h00FF : 16'hFF00;
      default: return 16'h1357 * 16'(i + 3 + c);
    endcase
  endfunction

  // Reference model: scan offsets counted from the period edge
  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (rst_n) begin
      edges++;
      if (off >= 0) begin
        if (off == LAT + 2 * HALF * (mwide ? 16 : 8) - 1) begin
          e0lo = mp0[7:0]; e1lo = mp1[7:0];
          e0hi = mwide ? mp0[15:8] : 8'h00;
          e1hi = mwide ? mp1[15:8] : 8'h00;
          off = -1;
        end else off++;
      end
      if (edges % PER == 0) begin
        off = 0; mwide = wide_mode; mp0 = pat0; mp1 = pat1;
      end
    end
  end

  task automatic chk1(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, nm, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      logic xl, xc;
      xl = (off >= 0) && (off < LAT);
      xc = (off >= LAT) && (((off - LAT) % (2 * HALF)) >= HALF);
      if (!rst_n) begin
        // R1 reset state
        chk1("R1", "reset outputs", {pad_latch, pad_clk, pad0_lo, pad0_hi, pad1_lo, pad1_hi}, 0);
      end else begin
        chk1("R2", "pad_latch", pad_latch, xl);          // R2
        chk1("R3/R4", "pad_clk", pad_clk, xc);           // R3 pulse shape, R4 pulse count
        chk1("R5/R6/R8", "pad0_lo", pad0_lo, e0lo);
        chk1("R5/R6/R8", "pad1_lo", pad1_lo, e1lo);
        chk1("R5/R7", "pad0_hi", pad0_hi, e0hi);
        chk1("R5/R7", "pad1_hi", pad1_hi, e1hi);
      end
    end
    // behavioural controllers: load on latch, advance on each rising clock
    if (pad_latch) rises0 = 0;
    else if (pad_clk && !prev_clk) rises0++;
    prev_clk = pad_clk;
    pad0_sd = (rises0 < 16) ? ~pat0[rises0] : 1'b0;
    pad1_sd = (rises0 < 16) ? ~pat1[rises0] : 1'b0;
    // stimulus, applied between scans
    if (rst_n && (edges % PER == PER - 5)) begin
      int s;
      s = edges / PER;
      pat0 = mkpat(s, 0);
      pat1 = mkpat(s, 1);
      wide_mode = ((s % 4) != 1) && ((s % 4) != 2) ? 1'b1 : 1'b0;
      pad0_sd = ~pat0[0];
      pad1_sd = ~pat1[0];
    end
    // R4: toggle mode in the middle of some scans
    if (rst_n && (edges % PER == 20) && ((edges / PER) % 3 == 2))
      wide_mode = ~wide_mode;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    while (edges < (NSCAN + 1) * PER && cyc < 50000) @(posedge clk);
    if (cyc >= 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 50000", cyc);
    end
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule